// File: doc/BRIEF.md
# Chained Token Readout Controller

Each front-end chip on a shared serial readout bus carries one of these controllers. The chips are read in turn. A chip begins sending when a rising edge arrives on its start line. The first chip in the chain gets that edge from the acquisition system. Every later chip gets it from the end pulse of the chip before it. Readout runs only after acquisition and conversion have finished, and the controller is idle the rest of the time.

A readout frame is a word count followed by that many stored words. All words go out MSB first, one bit per clock, on an active-low shared data line. A transmit-active line, also active low, is pulled for the whole frame. One clock after the last bit, the controller pulses an end line to hand the token on. A chip that holds no events still sends a count of zero and passes the token.

Each chip has two start inputs and two end outputs. A static path-select bit chooses one start input and the matching end output. The chain can then be wired to skip a dead neighbour.

Top module: `tkr_token_readout`

## Requirements
- R1: While reset is asserted and after reset is released, `dout_n` and `trans_on_n` are 1 (released) and `end_a`/`end_b` are 0.
- R2: A rising edge of the selected start line passes a two-flop synchroniser and an edge detector. A start that is first sampled high at clock edge t0 pulls `trans_on_n` low after edge t0+2.
- R3: The frame is WORD_W bits of the value on `word_count`, captured at the start, followed by the words read from addresses 0, 1, … count-1 on `mem_addr`/`mem_data`. Every word goes out MSB first, one bit per clock, with no gaps.
- R4: While transmitting, `dout_n` is the inverse of the current bit: low for a 1, high for a 0. When not transmitting, `dout_n` is released high.
- R5: `trans_on_n` is low for exactly WORD_W×(count+1) consecutive clocks per readout, and high at all other times.
- R6: The selected end output is high for exactly one clock, in the clock right after the last frame bit.
- R7: `path_sel`=0 uses `start_a`/`end_a` and `path_sel`=1 uses `start_b`/`end_b`. Edges on the unselected start line are ignored, and the unselected end line stays 0.
- R8: With a count of zero, the frame is WORD_W zero bits followed by the end pulse.
- R9: A start edge that arrives during a readout or during its end pulse is ignored. A start line held high causes only one readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| path_sel | input | 1 | Chooses start/end pair: 0 = A, 1 = B (static) |
| start_a | input | 1 | Start line A, asynchronous |
| start_b | input | 1 | Start line B, asynchronous |
| word_count | input | WORD_W | Number of stored words, held stable during readout |
| mem_addr | output | ADDR_W | Read address into the stored-word memory |
| mem_data | input | WORD_W | Word at `mem_addr`, combinational read |
| end_a | output | 1 | Token hand-off pulse A |
| end_b | output | 1 | Token hand-off pulse B |
| dout_n | output | 1 | Shared serial data, active low |
| trans_on_n | output | 1 | Shared transmit-active flag, active low |

## Verification
If the bit counter or the words-left counter holds a wrong value, the frame length changes. `trans_on_n` then stays low one clock too long or too short, and the end pulse shifts with it. This shows up in the same cycle the frame should have ended. A wrong address or a wrong shift shows up as a mismatching `dout_n` bit in the first cycle that carries the affected bit. A restart leak or a wrong path choice shows up within three clocks of the offending start edge, as a `trans_on_n` fall or an end pulse where none is due.

// File: rtl/tkr_pkg.sv
package tkr_pkg;

    typedef enum logic [1:0] {
        TKR_IDLE = 2'd0,
        TKR_SEND = 2'd1,
        TKR_END  = 2'd2
    } tkr_state_e;

endpackage

// File: rtl/tkr_sync.sv
module tkr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/tkr_frame_fsm.sv
module tkr_frame_fsm
    import tkr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_lvl,
    input  logic [WORD_W-1:0] word_count,
    input  logic [WORD_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              tx_active,
    output logic              tx_bit,
    output logic              done_pulse
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        tkr_state_e        state;
        logic [WORD_W-1:0] shreg;
        logic [BIT_W-1:0]  bitcnt;
        logic [WORD_W-1:0] left;
        logic [ADDR_W-1:0] addr;
        logic              lvl_prev;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic start_edge;

    always_comb begin
        nxt_d          = cur_q;
        start_edge     = start_lvl & ~cur_q.lvl_prev;
        nxt_d.lvl_prev = start_lvl;
        case (cur_q.state)
            TKR_IDLE: begin
                if (start_edge) begin
                    nxt_d.state  = TKR_SEND;
                    nxt_d.shreg  = word_count;
                    nxt_d.left   = word_count;
                    nxt_d.bitcnt = LAST_BIT;
                    nxt_d.addr   = '0;
                end
            end
            TKR_SEND: begin
                if (cur_q.bitcnt != '0) begin
                    nxt_d.shreg  = {cur_q.shreg[WORD_W-2:0], 1'b0};
                    nxt_d.bitcnt = cur_q.bitcnt - 1'b1;
                end else if (cur_q.left == '0) begin
                    nxt_d.state = TKR_END;
                end else begin
                    nxt_d.shreg  = mem_data;
                    nxt_d.left   = cur_q.left - 1'b1;
                    nxt_d.addr   = cur_q.addr + 1'b1;
                    nxt_d.bitcnt = LAST_BIT;
                end
            end
            TKR_END:  nxt_d.state = TKR_IDLE;
            default:  nxt_d.state = TKR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= TKR_IDLE;
            cur_q.shreg    <= '0;
            cur_q.bitcnt   <= '0;
            cur_q.left     <= '0;
            cur_q.addr     <= '0;
            cur_q.lvl_prev <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_addr   = cur_q.addr;
    assign tx_active  = (cur_q.state == TKR_SEND);
    assign tx_bit     = cur_q.shreg[WORD_W-1];
    assign done_pulse = (cur_q.state == TKR_END);

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == TKR_SEND && cur_q.bitcnt != '0) |=>
        (cur_q.state == TKR_SEND && cur_q.bitcnt == $past(cur_q.bitcnt) - 1'b1)); // R3

    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == TKR_END) |=> (cur_q.state == TKR_IDLE)); // R6

    AST_END_ALL_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == TKR_END) |-> (cur_q.left == '0)); // R5

    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == TKR_SEND && $past(cur_q.state) != TKR_SEND) |->
        ($past(cur_q.state) == TKR_IDLE)); // R9

endmodule

// File: rtl/tkr_token_readout.sv
module tkr_token_readout #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_sel,
    input  logic              start_a,
    input  logic              start_b,
    input  logic [WORD_W-1:0] word_count,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_data,
    output logic              end_a,
    output logic              end_b,
    output logic              dout_n,
    output logic              trans_on_n
);

    localparam int N_PATHS = 2;

    logic [N_PATHS-1:0] start_raw;
    logic [N_PATHS-1:0] start_sync;
    logic               tx_active, tx_bit, done_pulse;

    assign start_raw = {start_b, start_a};

    for (genvar p = 0; p < N_PATHS; p++) begin : g_sync
        tkr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (start_raw[p]),
            .level_o (start_sync[p])
        );
    end

    tkr_frame_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_lvl  (start_sync[path_sel]),
        .word_count (word_count),
        .mem_data   (mem_data),
        .mem_addr   (mem_addr),
        .tx_active  (tx_active),
        .tx_bit     (tx_bit),
        .done_pulse (done_pulse)
    );

    assign end_a      = done_pulse & ~path_sel;
    assign end_b      = done_pulse &  path_sel;
    assign dout_n     = ~(tx_active & tx_bit);
    assign trans_on_n = ~tx_active;

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_a && end_b)); // R7

    AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trans_on_n |-> dout_n); // R4

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (end_a || end_b) |-> ($past(!trans_on_n) && trans_on_n)); // R6

endmodule

// File: tb/tkr_token_readout_tb.sv
module tkr_token_readout_tb;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              path_sel = 1'b0;
    logic              start_a = 1'b0;
    logic              start_b = 1'b0;
    logic [WORD_W-1:0] word_count = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_data;
    logic              end_a, end_b, dout_n, trans_on_n;

    logic [WORD_W-1:0] mem [16];

    always #2.5 clk = ~clk;

    assign mem_data = mem[mem_addr[3:0]];

    tkr_token_readout #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .path_sel(path_sel),
        .start_a(start_a), .start_b(start_b), .word_count(word_count),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .end_a(end_a), .end_b(end_b), .dout_n(dout_n), .trans_on_n(trans_on_n)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tx_cycles = 0;
    int end_pulses = 0;

    // reference model: 0/1 = frame bit, 2 = end pulse, 3 = idle
    int q[$];
    int cur = 3;
    bit h1, h2, h3;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete(); cur = 3; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit lvl, edge_seen;
            lvl = path_sel ? start_b : start_a;
            edge_seen = h2 && !h3;
            if (cur == 3 && q.size() == 0 && edge_seen) begin
                for (int b = WORD_W - 1; b >= 0; b--) q.push_back(int'(word_count[b]));
                for (int w = 0; w < int'(word_count); w++)
                    for (int b = WORD_W - 1; b >= 0; b--) q.push_back(int'(mem[w][b]));
                q.push_back(2);
            end
            cur = (q.size() != 0) ? q.pop_front() : 3;
            h3 = h2; h2 = h1; h1 = lvl;
        end
        if (cycles == 100000) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel_end, oth_end;
            int exp_dout;
            sel_end  = path_sel ? end_b : end_a;
            oth_end  = path_sel ? end_a : end_b;
            exp_dout = (cur == 1) ? 0 : 1;
            check(dout_n == exp_dout, (cur < 2) ? "R3 dout_n" : "R4 dout_n", dout_n, exp_dout);
            check(trans_on_n == (cur >= 2), "R5 trans_on_n", trans_on_n, int'(cur >= 2));
            check(sel_end == (cur == 2), "R6 selected end", sel_end, int'(cur == 2));
            check(oth_end == 1'b0, "R7 unselected end", oth_end, 0);
            if (!trans_on_n) tx_cycles++;
            if (end_a || end_b) end_pulses++;
        end
    end

    task automatic wait_idle();
        repeat (6) @(negedge clk);
        while (!(cur == 3 && q.size() == 0)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input bit line_b, input int len);
        if (line_b) start_b = 1'b1; else start_a = 1'b1;
        repeat (len) @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hA5C3 ^ WORD_W'(i * 16'h1357);
        mem[0] = 16'hFFFF;
        mem[1] = 16'h0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(dout_n == 1 && trans_on_n == 1, "R1 outputs in reset", {dout_n, trans_on_n}, 3);
        check(end_a == 0 && end_b == 0, "R1 end lines in reset", {end_a, end_b}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(trans_on_n == 1 && end_a == 0, "R1 after release", trans_on_n, 1);

        // R2 latency + R3 frame, path A, count 3
        path_sel = 0; word_count = 3; tx_cycles = 0; end_pulses = 0;
        start_a = 1'b1;
        @(negedge clk); check(trans_on_n == 1, "R2 latency t0", trans_on_n, 1);
        @(negedge clk); check(trans_on_n == 1, "R2 latency t1", trans_on_n, 1);
        @(negedge clk); check(trans_on_n == 0, "R2 latency t2", trans_on_n, 0);
        start_a = 1'b0;
        wait_idle();
        check(tx_cycles == WORD_W * 4, "R5 frame length", tx_cycles, WORD_W * 4);
        check(end_pulses == 1, "R6 end pulse count", end_pulses, 1);

        // R8: zero count
        word_count = 0; tx_cycles = 0; end_pulses = 0;
        pulse(0, 2);
        wait_idle();
        check(tx_cycles == WORD_W, "R8 zero-count length", tx_cycles, WORD_W);
        check(end_pulses == 1, "R8 zero-count token passed", end_pulses, 1);

        // R7: unselected line ignored while idle
        tx_cycles = 0; end_pulses = 0;
        pulse(1, 4);
        repeat (10) @(negedge clk);
        check(tx_cycles == 0, "R7 unselected start ignored", tx_cycles, 0);

        // R7: path B, count 2, line A toggled during readout
        path_sel = 1; word_count = 2; tx_cycles = 0; end_pulses = 0;
        repeat (3) @(negedge clk);
        pulse(1, 3);
        repeat (5) @(negedge clk);
        pulse(0, 3);
        wait_idle();
        check(tx_cycles == WORD_W * 3, "R7 path B length", tx_cycles, WORD_W * 3);
        check(end_pulses == 1, "R7 path B end", end_pulses, 1);

        // R9: retrigger during readout
        word_count = 5; tx_cycles = 0; end_pulses = 0;
        pulse(1, 2);
        repeat (20) @(negedge clk);
        pulse(1, 2);
        wait_idle();
        check(tx_cycles == WORD_W * 6, "R9 retrigger ignored", tx_cycles, WORD_W * 6);
        check(end_pulses == 1, "R9 single end", end_pulses, 1);

        // R9: level held high across the whole readout
        word_count = 1; tx_cycles = 0; end_pulses = 0;
        start_b = 1'b1;
        repeat (60) @(negedge clk);
        check(tx_cycles == WORD_W * 2, "R9 held level one readout", tx_cycles, WORD_W * 2);
        check(end_pulses == 1, "R9 held level one end", end_pulses, 1);
        start_b = 1'b0;
        repeat (5) @(negedge clk);

        // R3: longer frame, path A again
        path_sel = 0; word_count = 12; tx_cycles = 0; end_pulses = 0;
        repeat (3) @(negedge clk);
        pulse(0, 1);
        wait_idle();
        check(tx_cycles == WORD_W * 13, "R3 long frame length", tx_cycles, WORD_W * 13);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule